// File: doc/BRIEF.md
# Speculative Indirect-Branch Path History Buffer

This block keeps an ordered, per-thread list of indirect branches seen by the front end. Each entry carries the branch PC, its target and a sequence number. New branches join at the young end. The resolved target of the newest branch can be patched in place. Retirement works by sequence number: entries are first marked as committed, and once a fixed number of committed entries has built up, the oldest one is dropped. A misprediction cuts off every entry younger than a given sequence number.

A hashing target predictor reads the targets of the most recent entries, newest first, through a flat view port that has a valid bit per slot. The list is a circular buffer. It holds three pieces of state: an oldest-entry index, an occupancy count, and a count of committed entries measured from the oldest end. The squash compares every live entry against the bound in parallel, so it finishes in a single cycle.

The buffer accepts one operation per clock. When several requests arrive together, a fixed priority picks the one that acts, and the rest are ignored for that cycle.

Top module: `path_hist_buf`

## Requirements
- R1: After reset, occ and ncmt are 0, full is 0, and every bit of view_vld is 0.
- R2: A record that acts appends the entry {rec_pc, rec_tgt, rec_seq} at the young end and raises occ by one. The new entry then appears on young_pc, young_seq and view slot 0.
- R3: full is 1 exactly when occ equals DEPTH, and occ never exceeds DEPTH. A record made while full is dropped and leaves every output unchanged.
- R4: A fill replaces the target of the youngest entry with fill_tgt and keeps that entry's PC, its sequence number and occ. A fill on an empty buffer changes nothing.
- R5: A commit on an empty buffer changes nothing.
- R6: A commit acts only when ncmt < occ and the sequence number of the entry at offset ncmt from the oldest is at most cmt_seq, compared as unsigned numbers. Otherwise it changes nothing.
- R7: When a commit acts and ncmt < HIST_N, ncmt rises by one. When a commit acts and ncmt >= HIST_N, the oldest entry is removed, occ drops by one and ncmt stays the same. ncmt never exceeds HIST_N.
- R8: A squash with bound sq_seq scans from the oldest entry and removes the first entry whose sequence number exceeds sq_seq, together with every entry younger than it, in one cycle. If no entry exceeds the bound, nothing changes. ncmt is not altered.
- R9: View slot i (bits [i*TGT_W +: TGT_W], where slot 0 is the youngest) holds the target of the (i+1)-th youngest entry. view_vld[i] is 1 exactly when i < min(HIST_N, occ). Slots that are not valid read as 0.
- R10: At most one operation acts per cycle. The priority, from highest to lowest, is squash, fill, commit, record. Any lower-priority request raised in the same cycle has no effect.
- R11: Every output depends only on the stored state. An operation requested in a cycle shows on the outputs after the next rising clock edge and not before.

Parameters: DEPTH (a power of two, default 8), HIST_N (default 4, must be below DEPTH), PC_W and TGT_W (default 16), SEQ_W (default 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_vld | input | 1 | Request to append a branch |
| rec_pc | input | PC_W | PC of the appended branch |
| rec_tgt | input | TGT_W | Target of the appended branch |
| rec_seq | input | SEQ_W | Sequence number of the appended branch |
| fill_vld | input | 1 | Request to replace the youngest target |
| fill_tgt | input | TGT_W | Replacement target |
| cmt_vld | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Sequence number being committed |
| sq_vld | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash bound; entries above it are removed |
| full | output | 1 | Buffer holds DEPTH entries |
| occ | output | $clog2(DEPTH+1) | Number of entries held |
| ncmt | output | $clog2(DEPTH+1) | Number of committed entries, counted from the oldest |
| young_pc | output | PC_W | PC of the youngest entry, 0 when empty |
| young_seq | output | SEQ_W | Sequence number of the youngest entry, 0 when empty |
| view_tgt | output | HIST_N*TGT_W | Targets of the newest entries, newest in slot 0 |
| view_vld | output | HIST_N | Valid bit per view slot |

## Verification
Every operation is due on the outputs exactly one rising edge after its request is driven, and no output may move before that edge. The bench drives each request on a falling edge. It first compares all outputs against the old model state just ahead of the rising edge, which shows that nothing changes early. It then updates its queue-based model at that edge and compares again on the following falling edge. Directed phases cover the commit threshold, pops at the HIST_N limit, fill and record while empty or full, and requests that collide in one cycle. A random phase follows to mix the operations.

// File: rtl/phb_pkg.sv
`timescale 1ns/1ps
package phb_pkg;
   typedef enum logic [2:0] {
      PHB_IDLE,
      PHB_SQUASH,
      PHB_FILL,
      PHB_COMMIT,
      PHB_RECORD
   } phb_op_e;

   // R10: one operation per cycle, fixed priority
   function automatic phb_op_e phb_pick(input logic sq, input logic fl,
                                        input logic cm, input logic rc);
      if (sq)      return PHB_SQUASH;
      else if (fl) return PHB_FILL;
      else if (cm) return PHB_COMMIT;
      else if (rc) return PHB_RECORD;
      else         return PHB_IDLE;
   endfunction
endpackage

// File: rtl/phb_age_match.sv
`timescale 1ns/1ps
// Parallel age compare: finds the oldest live entry above the squash bound.
module phb_age_match #(
   parameter int DEPTH = 8,
   parameter int SEQ_W = 8,
   parameter int PTR_W = 3,
   parameter int CNT_W = 4
) (
   input  logic [DEPTH*SEQ_W-1:0] seq_flat,
   input  logic [PTR_W-1:0]       head,
   input  logic [CNT_W-1:0]       occ,
   input  logic [SEQ_W-1:0]       bound,
   output logic                   hit,
   output logic [CNT_W-1:0]       cut
);
   logic [DEPTH-1:0] above;

   for (genvar k = 0; k < DEPTH; k++) begin : g_off
      logic [PTR_W-1:0] slot;
      assign slot     = head + PTR_W'(k);
      assign above[k] = (CNT_W'(k) < occ) &&
                        (seq_flat[int'(slot)*SEQ_W +: SEQ_W] > bound);
   end

   always_comb begin
      hit = |above;
      cut = '0;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         if (above[k]) cut = CNT_W'(k);
      end
   end
endmodule

// File: rtl/phb_commit_gate.sv
`timescale 1ns/1ps
// Decides whether a commit acts and whether it retires the oldest entry.
module phb_commit_gate #(
   parameter int HIST_N = 4,
   parameter int SEQ_W  = 8,
   parameter int CNT_W  = 4
) (
   input  logic [CNT_W-1:0] occ,
   input  logic [CNT_W-1:0] ncmt,
   input  logic [SEQ_W-1:0] ptr_seq,
   input  logic [SEQ_W-1:0] cmt_seq,
   output logic             act,
   output logic             pop
);
   assign act = (occ != '0) && (ncmt < occ) && (ptr_seq <= cmt_seq);
   assign pop = act && (ncmt >= CNT_W'(HIST_N));
endmodule

// File: rtl/phb_hash_view.sv
`timescale 1ns/1ps
// Newest-first target window for the hashing predictor.
module phb_hash_view #(
   parameter int DEPTH  = 8,
   parameter int HIST_N = 4,
   parameter int TGT_W  = 16,
   parameter int PTR_W  = 3,
   parameter int CNT_W  = 4
) (
   input  logic [DEPTH*TGT_W-1:0]  tgt_flat,
   input  logic [PTR_W-1:0]        tail,
   input  logic [CNT_W-1:0]        occ,
   output logic [HIST_N*TGT_W-1:0] view_tgt,
   output logic [HIST_N-1:0]       view_vld
);
   for (genvar i = 0; i < HIST_N; i++) begin : g_slot
      logic [PTR_W-1:0] idx;
      assign idx         = tail - PTR_W'(i + 1);
      assign view_vld[i] = (CNT_W'(i) < occ);
      assign view_tgt[i*TGT_W +: TGT_W] =
         view_vld[i] ? tgt_flat[int'(idx)*TGT_W +: TGT_W] : '0;
   end
endmodule

// File: rtl/path_hist_buf.sv
`timescale 1ns/1ps
module path_hist_buf
   import phb_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int HIST_N = 4,
   parameter int PC_W   = 16,
   parameter int TGT_W  = 16,
   parameter int SEQ_W  = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rec_vld,
   input  logic [PC_W-1:0]         rec_pc,
   input  logic [TGT_W-1:0]        rec_tgt,
   input  logic [SEQ_W-1:0]        rec_seq,
   input  logic                    fill_vld,
   input  logic [TGT_W-1:0]        fill_tgt,
   input  logic                    cmt_vld,
   input  logic [SEQ_W-1:0]        cmt_seq,
   input  logic                    sq_vld,
   input  logic [SEQ_W-1:0]        sq_seq,
   output logic                    full,
   output logic [CNT_W-1:0]        occ,
   output logic [CNT_W-1:0]        ncmt,
   output logic [PC_W-1:0]         young_pc,
   output logic [SEQ_W-1:0]        young_seq,
   output logic [HIST_N*TGT_W-1:0] view_tgt,
   output logic [HIST_N-1:0]       view_vld
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   // elaboration-time parameter checks
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("path_hist_buf: DEPTH must be a power of two, at least 2");
   end
   if (HIST_N < 1 || HIST_N >= DEPTH) begin : g_bad_hist
      $error("path_hist_buf: HIST_N must be in 1..DEPTH-1");
   end
   if (PC_W < 1 || TGT_W < 1 || SEQ_W < 1) begin : g_bad_width
      $error("path_hist_buf: field widths must be positive");
   end

   logic [PC_W-1:0]  pc_q  [DEPTH];
   logic [TGT_W-1:0] tgt_q [DEPTH];
   logic [SEQ_W-1:0] seq_q [DEPTH];

   logic [PTR_W-1:0] head_q;
   logic [CNT_W-1:0] occ_q;
   logic [CNT_W-1:0] ncmt_q;

   logic [DEPTH*SEQ_W-1:0] seq_flat;
   logic [DEPTH*TGT_W-1:0] tgt_flat;

   for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign seq_flat[g*SEQ_W +: SEQ_W] = seq_q[g];
      assign tgt_flat[g*TGT_W +: TGT_W] = tgt_q[g];
   end

   logic [PTR_W-1:0] tail, young, cptr;
   phb_op_e          op;
   logic             is_full, is_empty;

   assign tail     = head_q + PTR_W'(occ_q);
   assign young    = tail - PTR_W'(1);
   assign cptr     = head_q + PTR_W'(ncmt_q);
   assign is_full  = (occ_q == CNT_W'(DEPTH));
   assign is_empty = (occ_q == '0);
   assign op       = phb_pick(sq_vld, fill_vld, cmt_vld, rec_vld);

   logic             sq_hit;
   logic [CNT_W-1:0] sq_cut;
   logic             c_act, c_pop;

   phb_age_match #(
      .DEPTH(DEPTH), .SEQ_W(SEQ_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
   ) u_age (
      .seq_flat(seq_flat), .head(head_q), .occ(occ_q),
      .bound(sq_seq), .hit(sq_hit), .cut(sq_cut)
   );

   phb_commit_gate #(
      .HIST_N(HIST_N), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
   ) u_cmt (
      .occ(occ_q), .ncmt(ncmt_q), .ptr_seq(seq_q[cptr]),
      .cmt_seq(cmt_seq), .act(c_act), .pop(c_pop)
   );

   phb_hash_view #(
      .DEPTH(DEPTH), .HIST_N(HIST_N), .TGT_W(TGT_W),
      .PTR_W(PTR_W), .CNT_W(CNT_W)
   ) u_view (
      .tgt_flat(tgt_flat), .tail(tail), .occ(occ_q),
      .view_tgt(view_tgt), .view_vld(view_vld)
   );

   // control state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         occ_q  <= '0;
         ncmt_q <= '0;
      end else begin
         unique case (op)
            PHB_SQUASH: if (sq_hit) occ_q <= sq_cut;
            PHB_COMMIT: begin
               if (c_pop) begin
                  head_q <= head_q + PTR_W'(1);
                  occ_q  <= occ_q - CNT_W'(1);
               end else if (c_act) begin
                  ncmt_q <= ncmt_q + CNT_W'(1);
               end
            end
            PHB_RECORD: if (!is_full) occ_q <= occ_q + CNT_W'(1);
            default: ;
         endcase
      end
   end

   // entry storage, no reset needed: occupancy guards every read
   always_ff @(posedge clk) begin
      if (rst_n) begin
         if (op == PHB_RECORD && !is_full) begin
            pc_q[tail]  <= rec_pc;
            tgt_q[tail] <= rec_tgt;
            seq_q[tail] <= rec_seq;
         end else if (op == PHB_FILL && !is_empty) begin
            tgt_q[young] <= fill_tgt;
         end
      end
   end

   assign full      = is_full;
   assign occ       = occ_q;
   assign ncmt      = ncmt_q;
   assign young_pc  = is_empty ? '0 : pc_q[young];
   assign young_seq = is_empty ? '0 : seq_q[young];
endmodule

// File: rtl/path_hist_buf_chk.sv
`timescale 1ns/1ps
module path_hist_buf_chk #(
   parameter int DEPTH  = 8,
   parameter int HIST_N = 4,
   parameter int SEQ_W  = 8,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rec_vld,
   input logic              fill_vld,
   input logic              cmt_vld,
   input logic              sq_vld,
   input logic [SEQ_W-1:0]  sq_seq,
   input logic              full,
   input logic [CNT_W-1:0]  occ,
   input logic [CNT_W-1:0]  ncmt,
   input logic [SEQ_W-1:0]  young_seq,
   input logic [HIST_N-1:0] view_vld
);
   logic rec_only, cmt_only;
   assign rec_only = rec_vld && !sq_vld && !fill_vld && !cmt_vld;
   assign cmt_only = cmt_vld && !sq_vld && !fill_vld;

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CNT_W'(DEPTH));

   a_r3_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      rec_only && full |=> $stable(occ) && $stable(young_seq));

   a_r2_append_grows: assert property (@(posedge clk) disable iff (!rst_n)
      rec_only && !full |=> occ == $past(occ) + CNT_W'(1));

   a_r4_fill_keeps_shape: assert property (@(posedge clk) disable iff (!rst_n)
      fill_vld && !sq_vld |=> $stable(occ) && $stable(young_seq) && $stable(ncmt));

   a_r5_empty_commit: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_only && occ == '0 |=> occ == '0 && $stable(ncmt));

   a_r7_commit_cap: assert property (@(posedge clk) disable iff (!rst_n)
      ncmt <= CNT_W'(HIST_N));

   a_r8_squash_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      sq_vld |=> occ <= $past(occ) && $stable(ncmt));

   a_r8_squash_bound: assert property (@(posedge clk) disable iff (!rst_n)
      sq_vld && occ != '0 |=> occ == '0 || young_seq <= $past(sq_seq));

   a_r9_view_count: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(view_vld) == ((occ < CNT_W'(HIST_N)) ? int'(occ) : HIST_N));
endmodule

bind path_hist_buf path_hist_buf_chk #(
   .DEPTH(DEPTH), .HIST_N(HIST_N), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rec_vld(rec_vld), .fill_vld(fill_vld),
   .cmt_vld(cmt_vld), .sq_vld(sq_vld), .sq_seq(sq_seq), .full(full),
   .occ(occ), .ncmt(ncmt), .young_seq(young_seq), .view_vld(view_vld)
);

// File: tb/path_hist_buf_bench.sv
`timescale 1ns/1ps
module path_hist_buf_bench;
   localparam int DEPTH  = 8;
   localparam int HIST_N = 4;
   localparam int CNT_W  = $clog2(DEPTH + 1);

   typedef struct packed {
      logic [15:0] pc;
      logic [15:0] tgt;
      logic [7:0]  seq;
   } ent_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rec_vld = 0, fill_vld = 0, cmt_vld = 0, sq_vld = 0;
   logic [15:0] rec_pc = 0, rec_tgt = 0, fill_tgt = 0;
   logic [7:0]  rec_seq = 0, cmt_seq = 0, sq_seq = 0;
   logic full;
   logic [CNT_W-1:0] occ, ncmt;
   logic [15:0] young_pc;
   logic [7:0]  young_seq;
   logic [HIST_N*16-1:0] view_tgt;
   logic [HIST_N-1:0] view_vld;

   always #5 clk = ~clk;

   path_hist_buf #(.DEPTH(DEPTH), .HIST_N(HIST_N)) u_path_hist_buf (
      .clk(clk), .rst_n(rst_n),
      .rec_vld(rec_vld), .rec_pc(rec_pc), .rec_tgt(rec_tgt), .rec_seq(rec_seq),
      .fill_vld(fill_vld), .fill_tgt(fill_tgt),
      .cmt_vld(cmt_vld), .cmt_seq(cmt_seq),
      .sq_vld(sq_vld), .sq_seq(sq_seq),
      .full(full), .occ(occ), .ncmt(ncmt),
      .young_pc(young_pc), .young_seq(young_seq),
      .view_tgt(view_tgt), .view_vld(view_vld)
   );

   ent_t q[$];
   int   m_ncmt = 0;
   int   checks = 0;
   int   bad = 0;
   bit   done = 0;
   int   nseq = 10;

   task automatic chk(input string tag, input string what,
                      input longint got, input longint exp);
      checks++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
      end
   endtask

   task automatic compare(input string tag);
      int n;
      n = q.size();
      chk(tag, "occ", occ, n);
      chk({tag, " R3"}, "full", full, (n == DEPTH));
      chk({tag, " R7"}, "ncmt", ncmt, m_ncmt);
      chk({tag, " R2"}, "young_pc", young_pc, (n > 0) ? q[n-1].pc : 0);
      chk({tag, " R2"}, "young_seq", young_seq, (n > 0) ? q[n-1].seq : 0);
      for (int i = 0; i < HIST_N; i++) begin
         bit v;
         v = (i < n);
         chk({tag, " R9"}, $sformatf("view_vld[%0d]", i), view_vld[i], v);
         chk({tag, " R9"}, $sformatf("view_tgt[%0d]", i),
             view_tgt[i*16 +: 16], v ? q[n-1-i].tgt : 0);
      end
   endtask

   // reference model step, priority squash > fill > commit > record (R10)
   task automatic model_step();
      if (sq_vld) begin
         int cut;
         cut = -1;
         for (int i = 0; i < q.size(); i++)
            if (cut < 0 && q[i].seq > sq_seq) cut = i;
         if (cut >= 0) while (q.size() > cut) void'(q.pop_back());
      end else if (fill_vld) begin
         if (q.size() > 0) q[q.size()-1].tgt = fill_tgt;
      end else if (cmt_vld) begin
         if (q.size() > 0 && m_ncmt < q.size() && q[m_ncmt].seq <= cmt_seq) begin
            if (m_ncmt >= HIST_N) void'(q.pop_front());
            else m_ncmt++;
         end
      end else if (rec_vld) begin
         if (q.size() < DEPTH) q.push_back('{pc: rec_pc, tgt: rec_tgt, seq: rec_seq});
      end
   endtask

   // drive at falling edge, check nothing moved before the edge (R11),
   // then check the model one edge later
   task automatic cyc(input string tag);
      #2;
      compare({tag, " R11"});
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(tag);
      rec_vld = 0; fill_vld = 0; cmt_vld = 0; sq_vld = 0;
   endtask

   task automatic do_rec(input logic [15:0] pc, input logic [15:0] tg, input string tag);
      rec_vld = 1; rec_pc = pc; rec_tgt = tg; rec_seq = 8'(nseq); nseq++;
      cyc(tag);
   endtask

   task automatic do_cmt(input int s, input string tag);
      cmt_vld = 1; cmt_seq = 8'(s); cyc(tag);
   endtask

   task automatic do_sq(input int s, input string tag);
      sq_vld = 1; sq_seq = 8'(s); cyc(tag);
   endtask

   task automatic do_fill(input logic [15:0] tg, input string tag);
      fill_vld = 1; fill_tgt = tg; cyc(tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      // R2 appends, R9 view filling up
      do_rec(16'h1000, 16'hA000, "R2");
      do_rec(16'h1004, 16'hA004, "R2");
      do_rec(16'h1008, 16'hA008, "R9");
      // R4 patch youngest target
      do_fill(16'hBEEF, "R4");
      // R6 commit below the oldest seq (10) does nothing
      do_cmt(9, "R6");
      do_cmt(10, "R6");
      do_cmt(12, "R6");
      do_cmt(12, "R6");
      do_cmt(12, "R6"); // ncmt == occ: no action
      // fill up to DEPTH, then R3 drop
      for (int i = 0; i < 5; i++) do_rec(16'(16'h2000 + i*4), 16'(16'hC000 + i), "R3");
      do_rec(16'h3000, 16'hDEAD, "R3");
      // R7 reach HIST_N, then pop oldest
      do_cmt(13, "R7");
      do_cmt(14, "R7");
      do_cmt(15, "R7");
      // R8 squash partial, then nothing above bound
      do_sq(16, "R8");
      do_sq(200, "R8");
      // R10 collisions
      sq_vld = 1; sq_seq = 8'd14; rec_vld = 1; rec_pc = 16'h4000; rec_seq = 8'(nseq); nseq++;
      cyc("R10");
      fill_vld = 1; fill_tgt = 16'h7777; cmt_vld = 1; cmt_seq = 8'd250;
      rec_vld = 1; rec_pc = 16'h4100; rec_seq = 8'(nseq); nseq++;
      cyc("R10");
      cmt_vld = 1; cmt_seq = 8'd250; rec_vld = 1; rec_pc = 16'h4200; rec_seq = 8'(nseq); nseq++;
      cyc("R10");
      // empty it, then R5 and R4 on empty
      do_sq(0, "R8");
      do_cmt(250, "R5");
      do_fill(16'h5555, "R4");
      // random mix
      for (int c = 0; c < 400; c++) begin
         int r;
         r = $urandom % 100;
         if (r < 10 && q.size() > 0) begin
            sq_vld = 1;
            sq_seq = q[$urandom % q.size()].seq;
         end
         if ((($urandom % 100) < 15)) begin
            fill_vld = 1; fill_tgt = 16'($urandom);
         end
         if ((($urandom % 100) < 35)) begin
            cmt_vld = 1;
            cmt_seq = (m_ncmt < q.size()) ? 8'(q[m_ncmt].seq + ($urandom % 2) - 1) : 8'(nseq);
         end
         if ((($urandom % 100) < 50) && nseq < 250) begin
            rec_vld = 1; rec_pc = 16'($urandom); rec_tgt = 16'($urandom);
            rec_seq = 8'(nseq); nseq++;
         end
         cyc("R10");
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule